// File: doc/BRIEF.md
# Effective Address Generator

This block turns a one-word or two-word instruction into a 15-bit effective address for a word-addressed machine whose three index registers live in ordinary memory at words 1, 2 and 3. A short instruction carries a signed 8-bit displacement. That displacement is added either to the address of the next instruction or to an index register. A long instruction carries a full address in its second word. An index tag can be added to that address, and an indirect flag makes the result point at the word that holds the final address.

Instructions enter on a valid/ready stream. Results leave on a second valid/ready stream that carries the address and a flag that is set when the instruction occupies two words. Any index or indirect lookup is fetched through a request/acknowledge read port, one read at a time. The index register is always read before the pointer. Forms that need no read produce a result on the cycle after they are accepted, so a run of such forms flows at one per cycle.

Back-pressure rules:
- An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low while a lookup is under way.
- `in_ready` is also low while a result is waiting and `out_ready` is low.
- A result stays on the output, unchanged, until it is taken with `out_ready`.

Bits are numbered from the most significant end of a word, so bit 0 is `word[15]`.

Top module: `ea_gen`

## Requirements
- R1: `out_long` is set to bit 5 of the first word (`in_word0[10]`). Value 1 means a two-word instruction.
- R2: For a short instruction with tag 00, the address is (`in_iar` + 1 + the sign-extended `in_word0[7:0]`) mod 2^15. No memory read is made. The tag is bits 6 to 7 (`in_word0[9:8]`).
- R3: For a short instruction with tag n (n = 1, 2 or 3), the block reads memory word n once. The address is (the low 15 bits of that word + the sign-extended displacement) mod 2^15.
- R4: For a long instruction with tag 00 and the indirect flag clear, the address is `in_word1[14:0]` and no read is made. The indirect flag is bit 8 (`in_word0[7]`).
- R5: For a long instruction with tag n ≠ 00 and the indirect flag clear, the block reads word n once. The address is (`in_word1[14:0]` + the low 15 bits of that word) mod 2^15.
- R6: For a long instruction with the indirect flag set, the block first reads index word n if the tag is nonzero. It then reads the word at the (possibly indexed) address. The address produced is the low 15 bits of that second word.
- R7: `mem_req` stays high with `mem_addr` unchanged until the cycle in which `mem_ack` is sampled high. A request is never raised while `in_ready` is high.
- R8: `out_valid` rises only on the edge after an acceptance that needs no read, or after the acknowledge of the last required read.
- R9: While `out_valid` is high and `out_ready` is low, the output stays stable and `in_ready` is low. A result can be taken and a new instruction accepted on the same edge.
- R10: The opcode bits (`in_word0[15:11]`) never affect the result. In the short format, `in_word1` is ignored and `in_word0[7]` is a displacement bit rather than an indirect flag.
- R11: After reset, `out_valid` and `mem_req` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be taken |
| in_word0 | input | 16 | First instruction word |
| in_word1 | input | 16 | Second instruction word (used only in the long format) |
| in_iar | input | 15 | Address of the instruction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ea | output | 15 | Effective address |
| out_long | output | 1 | 1 when the instruction is two words |
| mem_req | output | 1 | Read request |
| mem_addr | output | 15 | Read address |
| mem_ack | input | 1 | Read acknowledge; data valid with it |
| mem_rdata | input | 16 | Read data |

## Verification
Handing a result to the consumer and accepting the next instruction can fall on the same edge. This is the case the back-pressure rules must get right. The bench provokes it by holding a result from an indexed short instruction with `out_ready` low, with the read acknowledge delayed by several cycles. It then raises `out_ready` in the same cycle that it presents a direct long instruction. The bench judges the outcome by requiring that `in_ready` is high in that cycle and that the new address replaces the old one one cycle later, with no read issued.

// File: rtl/eag_pkg.sv
package eag_pkg;
  // Bit positions in the first word (bit 0 of the numbering is the MSB).
  localparam int FMT_POS = 10;
  localparam int TAG_HI  = 9;
  localparam int TAG_LO  = 8;
  localparam int IND_POS = 7;
  localparam int TAG_W   = TAG_HI - TAG_LO + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XR   = 2'd1,
    ST_PTR  = 2'd2
  } eag_state_e;

  typedef struct packed {
    logic             is_long;
    logic [TAG_W-1:0] tag;
    logic             ind;
  } eag_fields_t;
endpackage

// File: rtl/eag_wrap_add.sv
module eag_wrap_add #(
  parameter int AW = 15
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] sum
);
  // Carry out of the top bit is dropped: arithmetic is modulo 2^AW.
  always_comb sum = a + b;
endmodule

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
#(
  parameter int AW     = 15,
  parameter int DISP_W = 8
) (
  input  logic [FMT_POS:0] word0_lo,
  input  logic [AW-1:0]    word1_addr,
  input  logic [AW-1:0]    iar,
  output eag_fields_t      fields,
  output logic [AW-1:0]    base,
  output logic [AW-1:0]    direct_ea,
  output logic             need_xr,
  output logic             need_ptr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] next_iar;
  logic [AW-1:0] rel_ea;

  generate
    if (AW > DISP_W) begin : g_sext
      assign disp_ext = {{(AW-DISP_W){word0_lo[DISP_W-1]}}, word0_lo[DISP_W-1:0]};
    end else begin : g_trunc
      assign disp_ext = word0_lo[AW-1:0];
    end
  endgenerate

  eag_wrap_add #(.AW(AW)) u_inc (.a(iar),      .b(ONE),      .sum(next_iar));
  eag_wrap_add #(.AW(AW)) u_rel (.a(next_iar), .b(disp_ext), .sum(rel_ea));

  always_comb begin
    fields.is_long = word0_lo[FMT_POS];
    fields.tag     = word0_lo[TAG_HI:TAG_LO];
    fields.ind     = word0_lo[FMT_POS] & word0_lo[IND_POS];
    need_xr        = (word0_lo[TAG_HI:TAG_LO] != '0);
    need_ptr       = fields.ind;
    base           = fields.is_long ? word1_addr : disp_ext;
    direct_ea      = fields.is_long ? word1_addr : rel_ea;
  end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
#(
  parameter int              AW      = 15,
  parameter int              DW      = 16,
  parameter logic [AW-1:0]   XR_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  eag_fields_t   fields,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] direct_ea,
  input  logic          need_xr,
  input  logic          need_ptr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_ea,
  output logic          out_long,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  eag_state_e       state_q;
  logic [AW-1:0]    base_q;
  logic [AW-1:0]    ptr_q;
  logic [TAG_W-1:0] tag_q;
  logic             ind_q;
  logic [AW-1:0]    idx_sum;
  logic [AW-1:0]    xr_addr;
  logic             slot_free;
  logic             accept;

  eag_wrap_add #(.AW(AW)) u_idx (.a(base_q), .b(mem_rdata[AW-1:0]), .sum(idx_sum));
  eag_wrap_add #(.AW(AW)) u_xra (.a(XR_BASE), .b(AW'(tag_q)), .sum(xr_addr));

  always_comb begin
    slot_free = !out_valid || out_ready;
    in_ready  = (state_q == ST_IDLE) && slot_free;
    accept    = in_valid && in_ready;
    mem_req   = (state_q != ST_IDLE);
    mem_addr  = (state_q == ST_XR) ? xr_addr : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      ptr_q     <= '0;
      tag_q     <= '0;
      ind_q     <= 1'b0;
      out_valid <= 1'b0;
      out_ea    <= '0;
      out_long  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            base_q   <= base;
            tag_q    <= fields.tag;
            ind_q    <= need_ptr;
            out_long <= fields.is_long;
            if (need_xr) begin
              state_q <= ST_XR;
            end else if (need_ptr) begin
              ptr_q   <= base;
              state_q <= ST_PTR;
            end else begin
              out_valid <= 1'b1;
              out_ea    <= direct_ea;
            end
          end
        end
        ST_XR: begin
          if (mem_ack) begin
            if (ind_q) begin
              ptr_q   <= idx_sum;
              state_q <= ST_PTR;
            end else begin
              out_valid <= 1'b1;
              out_ea    <= idx_sum;
              state_q   <= ST_IDLE;
            end
          end
        end
        ST_PTR: begin
          if (mem_ack) begin
            out_valid <= 1'b1;
            out_ea    <= mem_rdata[AW-1:0];
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import eag_pkg::*;
#(
  parameter int            AW      = 15,
  parameter int            DW      = 16,
  parameter int            DISP_W  = 8,
  parameter logic [AW-1:0] XR_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_word0,
  input  logic [DW-1:0] in_word1,
  input  logic [AW-1:0] in_iar,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_ea,
  output logic          out_long,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  eag_fields_t   fields;
  logic [AW-1:0] base;
  logic [AW-1:0] direct_ea;
  logic          need_xr;
  logic          need_ptr;

  eag_decode #(.AW(AW), .DISP_W(DISP_W)) u_dec (
    .word0_lo   (in_word0[FMT_POS:0]),
    .word1_addr (in_word1[AW-1:0]),
    .iar        (in_iar),
    .fields     (fields),
    .base       (base),
    .direct_ea  (direct_ea),
    .need_xr    (need_xr),
    .need_ptr   (need_ptr)
  );

  eag_ctrl #(.AW(AW), .DW(DW), .XR_BASE(XR_BASE)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .fields    (fields),
    .base      (base),
    .direct_ea (direct_ea),
    .need_xr   (need_xr),
    .need_ptr  (need_ptr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ea    (out_ea),
    .out_long  (out_long),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_ea,
  input logic          out_long,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_no_req_when_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);

  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(in_valid && in_ready) || $past(mem_req && mem_ack)));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ea) && $stable(out_long)));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind ea_gen eag_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_ea    (out_ea),
  .out_long  (out_long),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_word0 = 0;
  logic [15:0] in_word1 = 0;
  logic [14:0] in_iar = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [14:0] out_ea;
  logic        out_long;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic        mem_ack = 0;
  logic [15:0] mem_rdata = 0;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int wait_cnt = 0;
  int nrd = 0;
  int viol = 0;
  logic [14:0] held_addr = 0;
  logic [14:0] rd_log [0:7];
  logic [15:0] xr [1:3];

  always #10 clk = ~clk;

  ea_gen u_dut (.*);

  function automatic logic [15:0] memval(input logic [14:0] a);
    if (a >= 15'd1 && a <= 15'd3) return xr[a[1:0]];
    return {1'b1, a ^ 15'h2A5A};
  endfunction

  function automatic logic [15:0] mk(input logic [4:0] op, input logic fmt,
                                     input logic [1:0] tag, input logic [7:0] lo);
    return {op, fmt, tag, lo};
  endfunction

  function automatic logic [14:0] sx(input logic [7:0] d);
    return {{7{d[7]}}, d};
  endfunction

  // memory responder: acknowledges after lat idle cycles
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt == 0) held_addr = mem_addr;
      else if (mem_addr != held_addr) viol++;
      if (wait_cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= memval(mem_addr);
        if (nrd < 8) rd_log[nrd] = mem_addr;
        nrd++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic run_one(input logic [15:0] w0, input logic [15:0] w1, input logic [14:0] iar,
                         input logic [14:0] exp_ea, input int exp_n,
                         input logic [14:0] a0, input logic [14:0] a1,
                         input string req, output int cyc);
    nrd = 0;
    @(negedge clk);
    in_word0 = w0; in_word1 = w1; in_iar = iar; in_valid = 1; out_ready = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    cyc = 1;
    while (!out_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk(out_valid, req, 32'(out_valid), 1);
    chk(out_ea == exp_ea, req, 32'(out_ea), 32'(exp_ea));
    chk(out_long == w0[10], {req, " R1"}, 32'(out_long), 32'(w0[10]));
    chk(nrd == exp_n, {req, " reads"}, nrd, exp_n);
    if (exp_n >= 1) chk(rd_log[0] == a0, {req, " first read"}, 32'(rd_log[0]), 32'(a0));
    if (exp_n >= 2) chk(rd_log[1] == a1, {req, " second read"}, 32'(rd_log[1]), 32'(a1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid, "R11 out_valid", 32'(out_valid), 0);
    chk(!mem_req, "R11 mem_req", 32'(mem_req), 0);
    chk(in_ready, "R11 in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_short_rel();
    int c;
    lat = 0;
    run_one(mk(5'h00, 0, 2'b00, 8'h05), 16'h0, 15'd100, 15'd106, 0, 0, 0, "R2 fwd", c);
    chk(c == 1, "R8 direct latency", c, 1);
    run_one(mk(5'h1F, 0, 2'b00, 8'h80), 16'hFFFF, 15'd100, 15'(15'd101 + sx(8'h80)), 0, 0, 0,
            "R2 R10 neg disp ind-bit ignored", c);
    run_one(mk(5'h0A, 0, 2'b00, 8'h01), 16'h1234, 15'h7FFF, 15'h0001, 0, 0, 0, "R2 wrap", c);
  endtask

  task automatic t_short_idx();
    int c;
    lat = 1;
    run_one(mk(5'h03, 0, 2'b01, 8'hF0), 16'h0, 15'd500, 15'(xr[1][14:0] + sx(8'hF0)), 1, 15'd1, 0, "R3 xr1", c);
    run_one(mk(5'h03, 0, 2'b10, 8'h20), 16'h0, 15'd500, 15'(xr[2][14:0] + sx(8'h20)), 1, 15'd2, 0, "R3 xr2 wrap", c);
    run_one(mk(5'h11, 0, 2'b11, 8'h7F), 16'h0, 15'd500, 15'(xr[3][14:0] + 15'h7F), 1, 15'd3, 0, "R3 xr3", c);
  endtask

  task automatic t_long_direct();
    int c;
    lat = 0;
    run_one(mk(5'h07, 1, 2'b00, 8'h7F), 16'h9234, 15'd9, 15'h1234, 0, 0, 0, "R4 direct", c);
    chk(c == 1, "R8 R4 latency", c, 1);
    run_one(mk(5'h18, 1, 2'b00, 8'h7F), 16'h9234, 15'd9, 15'h1234, 0, 0, 0, "R10 R4 opcode ignored", c);
  endtask

  task automatic t_long_idx();
    int c;
    lat = 2;
    run_one(mk(5'h02, 1, 2'b11, 8'h00), 16'h0200, 15'd0, 15'(15'h0200 + xr[3][14:0]), 1, 15'd3, 0, "R5 xr3", c);
    run_one(mk(5'h02, 1, 2'b10, 8'h00), 16'h0020, 15'd0, 15'(15'h0020 + xr[2][14:0]), 1, 15'd2, 0, "R5 xr2 wrap", c);
  endtask

  task automatic t_long_ind();
    int c;
    logic [14:0] p;
    lat = 1;
    run_one(mk(5'h04, 1, 2'b00, 8'h80), 16'h1234, 15'd0, 15'h1234 ^ 15'h2A5A, 1, 15'h1234, 0, "R6 ind", c);
    p = 15'(15'h0100 + xr[2][14:0]);
    run_one(mk(5'h04, 1, 2'b10, 8'h80), 16'h0100, 15'd0, p ^ 15'h2A5A, 2, 15'd2, p, "R6 idx+ind order", c);
  endtask

  task automatic t_stall();
    logic [14:0] held;
    lat = 3; viol = 0; nrd = 0;
    @(negedge clk);
    out_ready = 0;
    in_word0 = mk(5'h01, 0, 2'b01, 8'h04); in_word1 = 0; in_iar = 0; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    for (int i = 0; i < 20 && !out_valid; i++) @(negedge clk);
    held = out_ea;
    chk(held == 15'(xr[1][14:0] + 15'd4), "R3 stalled result", 32'(held), 32'(xr[1][14:0] + 15'd4));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid && out_ea == held && !in_ready, "R9 hold under stall", 32'(out_ea), 32'(held));
    end
    chk(viol == 0, "R7 request address held", viol, 0);
    // drain and accept on the same edge
    out_ready = 1;
    in_word0 = mk(5'h00, 1, 2'b00, 8'h00); in_word1 = 16'h0ABC; in_valid = 1;
    #1;
    chk(in_ready, "R9 ready while draining", 32'(in_ready), 1);
    nrd = 0;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid && out_ea == 15'h0ABC && out_long, "R9 back-to-back result", 32'(out_ea), 32'h0ABC);
    chk(nrd == 0, "R9 R4 no read", nrd, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    xr[1] = 16'h8010; xr[2] = 16'h7FF0; xr[3] = 16'h0100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_short_rel();
    t_short_idx();
    t_long_direct();
    t_long_idx();
    t_long_ind();
    t_stall();
    summary();
  end
endmodule